// File: doc/BRIEF.md
# Flash program/erase controller

This block guards a small on-chip flash array behind a 32-bit register port and a separate memory-side port. Software opens the block with a fixed pair of key words. It then either programs 16-bit words through the memory port or erases a whole page through the registers. Each operation holds a busy flag for a parameterised number of cycles, which stands in for the array's real write time. Software polls that flag and waits for it to clear before it continues.

The register port has four word slots, selected by `reg_addr`:

| Slot | Use |
|---|---|
| 0 | Key |
| 1 | Control |
| 2 | Status |
| 3 | Target address |

Control has four bits:

| Bit | Meaning |
|---|---|
| 0 | Program enable |
| 1 | Page-erase enable |
| 2 | Start |
| 3 | Lock |

Status has two bits:

| Bit | Meaning |
|---|---|
| 0 | Busy |
| 1 | Write-protection error |

Register reads and array reads return their data on the clock edge after the request. A per-page protect mask blocks changes to selected pages.

Programming works like real flash: a stored word is the bitwise AND of its old contents and the new data. Only an erase turns bits back to 1. Reset puts every page in the erased state.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, control reads 0x8 (locked), status reads 0, busy is low, and every array half-word reads 0xFFFF.
- R2: Writing 0x45670123 and then 0xCDEF89AB to slot 0 while locked unlocks the block, so control bit 3 reads 0.
- R3: A key write whose value is wrong for its place in the sequence leaves the block locked. The correct pair then has no effect until the next reset.
- R4: Writing control with bit 3 set relocks the block and clears bits 0 and 1. While locked, a control write has no effect on bits 0 to 2.
- R5: With the block unlocked and not busy, a control write that sets bits 1 and 2 erases the page holding the slot 3 address. The erase asserts busy for ERASE_CYC cycles, and control bit 2 reads 1 while it runs. When it ends, bit 2 clears and the page reads 0xFFFF.
- R6: With control bit 0 set, a memory write starts a program that keeps busy high for PROG_CYC cycles. The addressed half-word then holds old AND new.
- R7: A program or erase aimed at a page whose `wp_mask` bit is 1 sets status bit 1, does not assert busy and leaves the array unchanged. Writing 1 to status bit 1 clears it.
- R8: While busy, every register write and memory write is ignored. Array reads return the contents from before the operation.
- R9: A memory write while control bit 0 is 0 leaves the array unchanged.
- R10: Reads return data one cycle after the request. A byte read returns the low byte for an even address and the high byte for an odd address, with bits 15:8 zero.
- R11: A control write that sets bit 2 without bit 1 starts no erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register slot |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| mem_wr | input | 1 | Half-word program request |
| mem_rd | input | 1 | Array read request |
| mem_byte | input | 1 | Byte-wide read when 1 |
| mem_addr | input | AW | Byte address in the array |
| mem_wdata | input | 16 | Program data |
| mem_rdata | output | 16 | Array read data, one cycle after mem_rd |
| wp_mask | input | NPAGES | Per-page write protection |
| busy | output | 1 | Operation in progress |

## Verification
A broken key sequencer shows at the next control read as a wrong value of bit 3. Its effect also carries into every later program attempt. A wrong busy count shows on the `busy` pin on the very edge where the reference model expects it to fall.

Errors in the array's blank flags, or in the read-modify-write capture, stay hidden until that half-word is read back. The bench therefore reads every word it touches right after each operation, and also during busy. A miscompare then lands within one or two cycles of the fault.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  typedef enum logic [1:0] {
    RA_KEY  = 2'd0,
    RA_CTRL = 2'd1,
    RA_STAT = 2'd2,
    RA_ADDR = 2'd3
  } reg_sel_e;

  localparam int CB_PROG   = 0;
  localparam int CB_PERASE = 1;
  localparam int CB_START  = 2;
  localparam int CB_LOCK   = 3;
  localparam int SB_BUSY   = 0;
  localparam int SB_WPERR  = 1;

  typedef enum logic [1:0] {
    KS_ARMED,
    KS_HALF,
    KS_OPEN,
    KS_DEAD
  } key_state_e;

  typedef enum logic {
    OP_PROG,
    OP_ERASE
  } op_kind_e;
endpackage

// File: rtl/fpe_keylock.sv
module fpe_keylock
  import fpe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        locked
);
  key_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KS_ARMED;
    end else if (relock) begin
      if (state_q != KS_DEAD) state_q <= KS_ARMED;
    end else if (key_wr) begin
      case (state_q)
        KS_ARMED: state_q <= (key_data == KEY_FIRST)  ? KS_HALF : KS_DEAD;
        KS_HALF:  state_q <= (key_data == KEY_SECOND) ? KS_OPEN : KS_DEAD;
        default:  state_q <= state_q;
      endcase
    end
  end

  assign locked = (state_q != KS_OPEN);

  // R3
  dead_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == KS_DEAD |=> state_q == KS_DEAD);

  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == KS_OPEN && $past(state_q) != KS_OPEN) |->
      $past(key_wr && key_data == KEY_SECOND));
endmodule

// File: rtl/fpe_busyseq.sv
module fpe_busyseq
  import fpe_pkg::*;
#(
  parameter int PROG_CYC  = 3,
  parameter int ERASE_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic go_prog,
  input  logic go_erase,
  output logic busy,
  output logic done_prog,
  output logic done_erase
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  op_kind_e      kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= OP_PROG;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (go_erase) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(ERASE_CYC - 1);
      kind_q <= OP_ERASE;
    end else if (go_prog) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(PROG_CYC - 1);
      kind_q <= OP_PROG;
    end
  end

  assign busy       = busy_q;
  assign done_prog  = busy_q && (cnt_q == '0) && (kind_q == OP_PROG);
  assign done_erase = busy_q && (cnt_q == '0) && (kind_q == OP_ERASE);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> busy_q);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (go_prog || go_erase) |-> !busy_q);
endmodule

// File: rtl/fpe_array.sv
module fpe_array #(
  parameter int NPAGES  = 8,
  parameter int PAGE_HW = 8,
  localparam int DEPTH = NPAGES * PAGE_HW,
  localparam int IW    = $clog2(DEPTH),
  localparam int PW    = $clog2(NPAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [15:0]   rd_data,
  input  logic          cap_en,
  input  logic [IW-1:0] cap_idx,
  output logic [15:0]   old_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [15:0]   wr_data,
  input  logic          erase_en,
  input  logic [PW-1:0] erase_page
);
  logic [15:0]      mem [DEPTH];
  logic [DEPTH-1:0] blank_q;
  logic [15:0]      rd_word_q, cap_word_q;
  logic             rd_blank_q, cap_blank_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (cap_en) cap_word_q <= mem[cap_idx];
  end

  always_ff @(posedge clk) begin
    if (cap_en) cap_blank_q <= blank_q[cap_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word_q  <= '0;
      rd_blank_q <= 1'b0;
    end else if (rd_en) begin
      rd_word_q  <= mem[rd_idx];
      rd_blank_q <= blank_q[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_q <= '1;
    end else begin
      if (erase_en) blank_q[int'(erase_page)*PAGE_HW +: PAGE_HW] <= '1;
      if (wr_en)    blank_q[wr_idx] <= 1'b0;
    end
  end

  assign rd_data  = rd_blank_q  ? 16'hFFFF : rd_word_q;
  assign old_data = cap_blank_q ? 16'hFFFF : cap_word_q;

  // R8
  blank_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en || erase_en) |=> $stable(blank_q));

  // R5
  erase_fills_chk: assert property (@(posedge clk) disable iff (rst)
    erase_en |=> blank_q[int'($past(erase_page))*PAGE_HW]);
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import fpe_pkg::*;
#(
  parameter int NPAGES     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int PROG_CYC   = 3,
  parameter int ERASE_CYC  = 10,
  localparam int AW = $clog2(NPAGES * PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mem_wr,
  input  logic              mem_rd,
  input  logic              mem_byte,
  input  logic [AW-1:0]     mem_addr,
  input  logic [15:0]       mem_wdata,
  output logic [15:0]       mem_rdata,
  input  logic [NPAGES-1:0] wp_mask,
  output logic              busy
);
  localparam int PAGE_HW = PAGE_BYTES / 2;
  localparam int OW      = $clog2(PAGE_BYTES);
  localparam int PW      = AW - OW;
  localparam int IW      = AW - 1;

  logic          locked, busy_w, done_prog, done_erase;
  logic          prog_q, per_q, start_q, err_q;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] pg_idx_q;
  logic [15:0]   pg_data_q, old_word, rd_word;
  logic [31:0]   reg_rdata_q;
  logic          rd_byte_q, rd_hi_q;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  logic wr_ok, key_wr, relock, ctrl_upd, erase_req, erase_prot, go_erase;
  logic prog_req, prog_prot, go_prog, err_set, err_clr;
  logic [PW-1:0] erase_page, prog_page;

  assign wr_ok      = reg_wr && !busy_w;
  assign key_wr     = wr_ok && sel == RA_KEY && locked;
  assign relock     = wr_ok && sel == RA_CTRL && reg_wdata[CB_LOCK];
  assign ctrl_upd   = wr_ok && sel == RA_CTRL && !reg_wdata[CB_LOCK] && !locked;
  assign erase_req  = ctrl_upd && reg_wdata[CB_START] && reg_wdata[CB_PERASE];
  assign erase_page = addr_q[AW-1:OW];
  assign erase_prot = wp_mask[erase_page];
  assign go_erase   = erase_req && !erase_prot;

  assign prog_req   = mem_wr && !reg_wr && !busy_w && prog_q && !locked;
  assign prog_page  = mem_addr[AW-1:OW];
  assign prog_prot  = wp_mask[prog_page];
  assign go_prog    = prog_req && !prog_prot;

  assign err_set = (erase_req && erase_prot) || (prog_req && prog_prot);
  assign err_clr = wr_ok && sel == RA_STAT && reg_wdata[SB_WPERR];

  fpe_keylock u_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (key_wr),
    .key_data (reg_wdata),
    .relock   (relock),
    .locked   (locked)
  );

  fpe_busyseq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .go_prog    (go_prog),
    .go_erase   (go_erase),
    .busy       (busy_w),
    .done_prog  (done_prog),
    .done_erase (done_erase)
  );

  fpe_array #(.NPAGES(NPAGES), .PAGE_HW(PAGE_HW)) u_arr (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (mem_rd),
    .rd_idx     (mem_addr[AW-1:1]),
    .rd_data    (rd_word),
    .cap_en     (go_prog),
    .cap_idx    (mem_addr[AW-1:1]),
    .old_data   (old_word),
    .wr_en      (done_prog),
    .wr_idx     (pg_idx_q),
    .wr_data    (pg_data_q & old_word),
    .erase_en   (done_erase),
    .erase_page (erase_page)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q  <= 1'b0;
      per_q   <= 1'b0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (relock) begin
        prog_q <= 1'b0;
        per_q  <= 1'b0;
      end else if (ctrl_upd) begin
        prog_q <= reg_wdata[CB_PROG];
        per_q  <= reg_wdata[CB_PERASE];
      end
      if (go_erase)        start_q <= 1'b1;
      else if (done_erase) start_q <= 1'b0;
      if (err_set)         err_q <= 1'b1;
      else if (err_clr)    err_q <= 1'b0;
      if (wr_ok && sel == RA_ADDR) addr_q <= reg_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (go_prog) begin
      pg_idx_q  <= mem_addr[AW-1:1];
      pg_data_q <= mem_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_q <= '0;
      rd_byte_q   <= 1'b0;
      rd_hi_q     <= 1'b0;
    end else begin
      if (reg_rd) begin
        case (sel)
          RA_CTRL: reg_rdata_q <= 32'({locked, start_q, per_q, prog_q});
          RA_STAT: reg_rdata_q <= 32'({err_q, busy_w});
          RA_ADDR: reg_rdata_q <= 32'(addr_q);
          default: reg_rdata_q <= '0;
        endcase
      end
      if (mem_rd) begin
        rd_byte_q <= mem_byte;
        rd_hi_q   <= mem_addr[0];
      end
    end
  end

  assign reg_rdata = reg_rdata_q;
  assign mem_rdata = rd_byte_q ? {8'h00, (rd_hi_q ? rd_word[15:8] : rd_word[7:0])} : rd_word;
  assign busy      = busy_w;

  // R5
  start_implies_erase_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (per_q && busy_w));

  // R4
  locked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> (!prog_q && !per_q && !start_q));

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(mem_wr || reg_wr));

  // R7
  prot_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (err_set && !busy_w) |=> !busy_w);
endmodule

// File: tb/flash_pe_ctrl_bench.sv
module flash_pe_ctrl_bench;
  localparam int NP = 8, PB = 16, PC = 3, EC = 10, AW = 7, NW = 64;
  localparam logic [31:0] K1 = 32'h4567_0123, K2 = 32'hCDEF_89AB;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, mem_wr = 0, mem_rd = 0, mem_byte = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [AW-1:0] mem_addr = 0;
  logic [15:0] mem_wdata = 0, mem_rdata;
  logic [NP-1:0] wp_mask = 8'h04;
  logic busy;

  always #10 clk = ~clk;

  flash_pe_ctrl #(.NPAGES(NP), .PAGE_BYTES(PB), .PROG_CYC(PC), .ERASE_CYC(EC)) u_flash_pe_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wp_mask(wp_mask), .busy(busy));

  int vectors = 0, fails = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  // behavioural reference model
  logic [15:0] m_mem [NW];
  int  m_kst;  // 0 armed, 1 half, 2 open, 3 dead
  bit  m_prog, m_per, m_start, m_err, m_busy, m_erase_op;
  int  m_cnt, m_addr, m_padr, m_pg;
  logic [15:0] m_pdat, hw;
  logic [31:0] exp_reg;
  logic [15:0] exp_mem;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) m_mem[i] = 16'hFFFF;
      m_kst = 0; m_prog = 0; m_per = 0; m_start = 0; m_err = 0; m_busy = 0;
      m_cnt = 0; m_addr = 0; exp_reg = 0; exp_mem = 0; m_erase_op = 0;
    end else begin
      if (reg_rd) begin
        case (reg_addr)
          2'd1: exp_reg = {28'd0, m_kst != 2, m_start, m_per, m_prog};
          2'd2: exp_reg = {30'd0, m_err, m_busy};
          2'd3: exp_reg = m_addr;
          default: exp_reg = 0;
        endcase
      end
      if (mem_rd) begin
        hw = m_mem[mem_addr >> 1];
        exp_mem = mem_byte ? (mem_addr[0] ? {8'h00, hw[15:8]} : {8'h00, hw[7:0]}) : hw;
      end
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_erase_op) begin
            for (int i = 0; i < PB / 2; i++) m_mem[(m_addr / PB) * (PB / 2) + i] = 16'hFFFF;
            m_start = 0;
          end else m_mem[m_padr >> 1] = m_mem[m_padr >> 1] & m_pdat;
        end else m_cnt--;
      end else if (reg_wr) begin
        case (reg_addr)
          2'd0: if (m_kst == 0) m_kst = (reg_wdata == K1) ? 1 : 3;
                else if (m_kst == 1) m_kst = (reg_wdata == K2) ? 2 : 3;
          2'd1: if (reg_wdata[3]) begin
                  if (m_kst != 3) m_kst = 0;
                  m_prog = 0; m_per = 0;
                end else if (m_kst == 2) begin
                  m_prog = reg_wdata[0]; m_per = reg_wdata[1];
                  if (reg_wdata[2] && reg_wdata[1]) begin
                    m_pg = m_addr / PB;
                    if (wp_mask[m_pg]) m_err = 1;
                    else begin m_start = 1; m_busy = 1; m_cnt = EC - 1; m_erase_op = 1; end
                  end
                end
          2'd2: if (reg_wdata[1]) m_err = 0;
          default: m_addr = int'(reg_wdata[AW-1:0]);
        endcase
      end else if (mem_wr && m_prog && m_kst == 2) begin
        m_pg = mem_addr / PB;
        if (wp_mask[m_pg]) m_err = 1;
        else begin m_busy = 1; m_cnt = PC - 1; m_erase_op = 0; m_padr = mem_addr; m_pdat = mem_wdata; end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      vectors += 3;
      if (busy !== m_busy) begin fails++; $display("FAIL %s busy act=%0b exp=%0b", cur_req, busy, m_busy); end
      if (reg_rdata !== exp_reg) begin fails++; $display("FAIL %s reg_rdata act=%h exp=%h", cur_req, reg_rdata, exp_reg); end
      if (mem_rdata !== exp_mem) begin fails++; $display("FAIL %s mem_rdata act=%h exp=%h", cur_req, mem_rdata, exp_mem); end
    end
  end

  task automatic idle(); reg_wr = 0; reg_rd = 0; mem_wr = 0; mem_rd = 0; mem_byte = 0; endtask
  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wreg(logic [1:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; @(negedge clk); idle();
  endtask
  task automatic mwr(logic [AW-1:0] a, logic [15:0] d);
    mem_wr = 1; mem_addr = a; mem_wdata = d; @(negedge clk); idle();
  endtask
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin fails++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask
  task automatic rreg(string req, logic [1:0] a, logic [31:0] e);
    reg_rd = 1; reg_addr = a; @(negedge clk); idle(); chk(req, reg_rdata, e);
  endtask
  task automatic rmem(string req, logic [AW-1:0] a, bit by, logic [15:0] e);
    mem_rd = 1; mem_addr = a; mem_byte = by; @(negedge clk); idle(); chk(req, {16'd0, mem_rdata}, {16'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    cyc(3); rst = 0; cmp_on = 1;
    cur_req = "R1";
    rreg("R1", 2'd1, 32'h8); rreg("R1", 2'd2, 0); rmem("R1", 7'h22, 0, 16'hFFFF);
    chk("R1", {31'd0, busy}, 0);
    cur_req = "R4";
    wreg(2'd1, 32'h1); rreg("R4", 2'd1, 32'h8);
    mwr(7'h12, 16'h1234); cyc(4); rmem("R4", 7'h12, 0, 16'hFFFF);
    cur_req = "R2";
    wreg(2'd0, K1); wreg(2'd0, K2); rreg("R2", 2'd1, 0);
    cur_req = "R6";
    wreg(2'd1, 32'h1);
    mwr(7'h12, 16'h12F4);
    cur_req = "R8";
    chk("R8", {31'd0, busy}, 1);
    rmem("R8", 7'h12, 0, 16'hFFFF);
    mwr(7'h14, 16'h0000);
    wreg(2'd1, 32'h0);
    cyc(3);
    cur_req = "R6";
    rmem("R6", 7'h12, 0, 16'h12F4); rmem("R8", 7'h14, 0, 16'hFFFF);
    rreg("R8", 2'd1, 32'h1);
    cur_req = "R10";
    rmem("R10", 7'h12, 1, 16'h00F4); rmem("R10", 7'h13, 1, 16'h0012);
    cur_req = "R6";
    mwr(7'h12, 16'hFF0F); cyc(4); rmem("R6", 7'h12, 0, 16'h1204);
    cur_req = "R7";
    mwr(7'h22, 16'h0000); chk("R7", {31'd0, busy}, 0);
    rreg("R7", 2'd2, 32'h2); cyc(3); rmem("R7", 7'h22, 0, 16'hFFFF);
    wreg(2'd2, 32'h2); rreg("R7", 2'd2, 0);
    cur_req = "R9";
    wreg(2'd1, 32'h0); mwr(7'h16, 16'h0000); cyc(4); rmem("R9", 7'h16, 0, 16'hFFFF);
    cur_req = "R11";
    wreg(2'd3, 32'h18); rreg("R10", 2'd3, 32'h18);
    wreg(2'd1, 32'h4); chk("R11", {31'd0, busy}, 0); rreg("R11", 2'd1, 0);
    cur_req = "R5";
    wreg(2'd1, 32'h6); chk("R5", {31'd0, busy}, 1);
    rreg("R5", 2'd1, 32'h6); rmem("R8", 7'h12, 0, 16'h1204);
    cyc(12);
    rreg("R5", 2'd1, 32'h2); rmem("R5", 7'h12, 0, 16'hFFFF); rmem("R5", 7'h1E, 0, 16'hFFFF);
    cur_req = "R7";
    wreg(2'd3, 32'h28); wreg(2'd1, 32'h6); chk("R7", {31'd0, busy}, 0);
    rreg("R7", 2'd2, 32'h2); wreg(2'd2, 32'h2);
    cur_req = "R4";
    wreg(2'd1, 32'h8); rreg("R4", 2'd1, 32'h8);
    wreg(2'd1, 32'h6); chk("R4", {31'd0, busy}, 0); rreg("R4", 2'd1, 32'h8);
    cur_req = "R3";
    wreg(2'd0, K1); wreg(2'd0, 32'h1); wreg(2'd0, K1); wreg(2'd0, K2);
    rreg("R3", 2'd1, 32'h8);
    cur_req = "R1";
    cmp_on = 0; rst = 1; cyc(2); rst = 0; cmp_on = 1;
    rmem("R1", 7'h12, 0, 16'hFFFF);
    wreg(2'd0, K1); wreg(2'd0, K2); rreg("R3", 2'd1, 0);
    cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule